// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer with a windowed service rule. Software reaches it through a simple 32-bit register port. Writes are synchronous. Reads are combinational from the address.

Software sets a 12-bit period value and picks an open-window fraction. It then starts the timer by writing a 32-bit unlock word. From then on the timer counts down once per clock. Software must service it with two key writes in a fixed order. The second key counts as a service only while the counter is inside the final fraction of the period.

Three events count as a fault:
- servicing before the window opens,
- writing a key value that does not belong at that point,
- the counter reaching zero.

Each fault sets a sticky status flag. It also fires a one-cycle reaction, either a non-maskable interrupt pulse or a reset request pulse. The fault reloads the counter, so the timer keeps running. Once started, the timer cannot be stopped except by a system reset.

Top module: `winwdt_top`

## Requirements
- R1: The timer starts only when the control register (offset 0x90) is written with exactly 0xA98559DA. While running, control reads back that value, and before it starts control reads 0. No later write to control stops it.
- R2: The preload register (0x94) keeps the low 12 bits of a write. Each reload sets the counter to preload shifted left by SHIFT bits. While running, the counter drops by one per clock and is readable at 0xA0.
- R3: A service is a key write (0x9C) of 0xE51A, which arms the timer, followed by 0xA35C. Inside the window this reloads the counter with no reaction. Key writes while the timer is stopped have no effect.
- R4: Window codes written to 0xA8 select the open fraction of the period: 0x50 for 1/2, 0x500 for 1/4, 0x5000 for 1/8, 0x50000 for 1/16, 0x500000 for 1/32. The second key is legal only if the counter value in the cycle of that write is at most the period shifted right by 1 to 5 bits, matching the code.
- R5: Three conditions are violations, and each reloads the counter:
  - a completed key pair outside the window;
  - any other key value, or 0xA35C when not armed;
  - the counter sitting at zero while running.
  The reaction appears in the cycle after the violating cycle.
- R6: Status (0x98) bit 1 is set by every violation. Writing 1 to bit 1 clears it, and writing 0 to bit 1 leaves it set.
- R7: Writing 0xA to reaction control (0xA4) selects a one-cycle interrupt pulse on violation. Any other value selects a one-cycle reset request pulse. The register reads 0xA or 0x5 accordingly, and the two pulses never occur together.
- R8: Preload and window writes made while running take effect only at the next reload. An undefined window code is ignored and the previous code reads back.
- R9: After reset the block reads as follows: control 0, status 0, counter 0, preload 0xFFF, window 0x50, reaction 0x5. Both reaction outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| nmi_o | output | 1 | One-cycle non-maskable interrupt pulse on violation |
| rst_req_o | output | 1 | One-cycle reset request pulse on violation |

## Verification
Every window code is swept against every service time from the first cycle after start up to one cycle before zero. The expected outcome, service or early fault, is computed from the counter value at the second key write. This separates the five window widths and pins down the exact boundary cycle of each.

The reaction selection alternates across the sweep, so each outcome is checked on both outputs. Directed sequences then cover the following:
- an undisturbed countdown to zero, which fixes the timeout cycle;
- stray and out-of-order keys;
- a wrong unlock word, and an attempt to stop the running timer;
- held preload and window updates, and undefined window codes;
- the status write-one-to-clear rule.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h90;
  localparam logic [7:0] OFS_PRE   = 8'h94;
  localparam logic [7:0] OFS_STS   = 8'h98;
  localparam logic [7:0] OFS_KEY   = 8'h9C;
  localparam logic [7:0] OFS_CNT   = 8'hA0;
  localparam logic [7:0] OFS_REACT = 8'hA4;
  localparam logic [7:0] OFS_WIN   = 8'hA8;

  localparam logic [31:0] UNLOCK_WORD = 32'hA98559DA;
  localparam logic [31:0] KEY_ARM     = 32'h0000E51A;
  localparam logic [31:0] KEY_SERVE   = 32'h0000A35C;
  localparam logic [31:0] REACT_IRQ   = 32'h0000000A;
  localparam logic [31:0] REACT_RST   = 32'h00000005;

  typedef enum logic {
    KS_ACTIVE = 1'b0,
    KS_ARMED  = 1'b1
  } key_st_t;

  // Window code -> right-shift amount of the period (0 = undefined code)
  function automatic logic [2:0] win_decode(input logic [31:0] code);
    case (code)
      32'h0000_0050: return 3'd1;
      32'h0000_0500: return 3'd2;
      32'h0000_5000: return 3'd3;
      32'h0005_0000: return 3'd4;
      32'h0050_0000: return 3'd5;
      default:       return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] win_encode(input logic [2:0] sh);
    case (sh)
      3'd2:    return 32'h0000_0500;
      3'd3:    return 32'h0000_5000;
      3'd4:    return 32'h0005_0000;
      3'd5:    return 32'h0050_0000;
      default: return 32'h0000_0050;
    endcase
  endfunction

endpackage

// File: rtl/winwdt_regs.sv
module winwdt_regs
  import winwdt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             viol,
  output logic [PRE_W-1:0] pre_pend,
  output logic [2:0]       wsh_pend,
  output logic             react_irq,
  output logic             sts_fault
);

  logic             pre_we, win_we, react_we, sts_we;
  logic [2:0]       win_dec;
  logic [PRE_W-1:0] pre_d;
  logic [2:0]       wsh_d;
  logic             react_d, sts_d;
  logic [PRE_W-1:0] pre_q;
  logic [2:0]       wsh_q;
  logic             react_q, sts_q;

  assign pre_we   = wr_en && (addr == OFS_PRE);
  assign win_we   = wr_en && (addr == OFS_WIN);
  assign react_we = wr_en && (addr == OFS_REACT);
  assign sts_we   = wr_en && (addr == OFS_STS);
  assign win_dec  = win_decode(wdata);

  always_comb begin
    pre_d   = pre_q;
    wsh_d   = wsh_q;
    react_d = react_q;
    sts_d   = sts_q;
    if (pre_we)
      pre_d = wdata[PRE_W-1:0];
    if (win_we && (win_dec != 3'd0))
      wsh_d = win_dec;
    if (react_we)
      react_d = (wdata == REACT_IRQ);
    if (viol)
      sts_d = 1'b1;
    else if (sts_we && wdata[1])
      sts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '1;
      wsh_q   <= 3'd1;
      react_q <= 1'b0;
      sts_q   <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      wsh_q   <= wsh_d;
      react_q <= react_d;
      sts_q   <= sts_d;
    end
  end

  assign pre_pend  = pre_q;
  assign wsh_pend  = wsh_q;
  assign react_irq = react_q;
  assign sts_fault = sts_q;

  AST_WIN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wsh_q >= 3'd1) && (wsh_q <= 3'd5)); // R8

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !(sts_we && wdata[1])) |=> sts_q); // R6

endmodule

// File: rtl/winwdt_counter.sv
module winwdt_counter #(
  parameter int PRE_W = 12,
  parameter int SHIFT = 13,
  localparam int CNT_W = PRE_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [PRE_W-1:0] pre,
  input  logic [2:0]       wsh,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero,
  output logic             win_open
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [2:0]       wsh_q, wsh_d;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] win_lim;
  logic             cnt_en;

  assign reload_val = {pre, {SHIFT{1'b0}}};
  assign cnt_en     = run && (cnt_q != '0);
  assign win_lim    = per_q >> wsh_q;

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    wsh_d = wsh_q;
    if (load) begin
      cnt_d = reload_val;
      per_d = reload_val;
      wsh_d = wsh;
    end else if (cnt_en) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      wsh_q <= 3'd1;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      wsh_q <= wsh_d;
    end
  end

  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);
  assign win_open = (cnt_q <= win_lim);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt_q != '0) && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= per_q)); // R2

endmodule

// File: rtl/winwdt_keyfsm.sv
module winwdt_keyfsm
  import winwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic        key_wr,
  input  logic [31:0] wdata,
  input  logic        cnt_zero,
  input  logic        win_open,
  output logic        run,
  output logic        load,
  output logic        viol
);

  logic    run_q, run_d;
  key_st_t st_q, st_d;
  logic    start, key_live, key_arm, key_serve;
  logic    svc_try, bad_key, early, svc_ok;

  assign start     = ctrl_wr && !run_q && (wdata == UNLOCK_WORD);
  assign key_live  = key_wr && run_q;
  assign key_arm   = key_live && (wdata == KEY_ARM);
  assign key_serve = key_live && (wdata == KEY_SERVE);
  assign svc_try   = key_serve && (st_q == KS_ARMED);
  assign bad_key   = key_live && !key_arm && !svc_try;
  assign early     = svc_try && !win_open;
  assign viol      = run_q && (cnt_zero || bad_key || early);
  assign svc_ok    = svc_try && win_open && !viol;
  assign load      = start || svc_ok || viol;

  always_comb begin
    run_d = run_q || start;
    st_d  = st_q;
    if (load)
      st_d = KS_ACTIVE;
    else if (key_arm)
      st_d = KS_ARMED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      st_q  <= KS_ACTIVE;
    end else begin
      run_q <= run_d;
      st_q  <= st_d;
    end
  end

  assign run = run_q;

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q); // R1

  AST_ARMED_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == KS_ARMED) |-> run_q); // R3

endmodule

// File: rtl/winwdt_top.sv
module winwdt_top
  import winwdt_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int SHIFT = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        nmi_o,
  output logic        rst_req_o
);

  localparam int CNT_W = PRE_W + SHIFT;

  logic [1:0]       rsync_q;
  logic             srst_n;
  logic             ctrl_wr, key_wr;
  logic             run, load, viol;
  logic [PRE_W-1:0] pre_pend;
  logic [2:0]       wsh_pend;
  logic             react_irq, sts_fault;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero, win_open;
  logic             nmi_q, nmi_d, rrq_q, rrq_d;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
  assign key_wr  = bus_wr && (bus_addr == OFS_KEY);

  winwdt_regs #(.PRE_W(PRE_W)) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .viol      (viol),
    .pre_pend  (pre_pend),
    .wsh_pend  (wsh_pend),
    .react_irq (react_irq),
    .sts_fault (sts_fault)
  );

  winwdt_keyfsm u_fsm (
    .clk      (clk),
    .rst_n    (srst_n),
    .ctrl_wr  (ctrl_wr),
    .key_wr   (key_wr),
    .wdata    (bus_wdata),
    .cnt_zero (cnt_zero),
    .win_open (win_open),
    .run      (run),
    .load     (load),
    .viol     (viol)
  );

  winwdt_counter #(.PRE_W(PRE_W), .SHIFT(SHIFT)) u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (run),
    .load     (load),
    .pre      (pre_pend),
    .wsh      (wsh_pend),
    .cnt      (cnt),
    .cnt_zero (cnt_zero),
    .win_open (win_open)
  );

  assign nmi_d = viol && react_irq;
  assign rrq_d = viol && !react_irq;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      nmi_q <= 1'b0;
      rrq_q <= 1'b0;
    end else begin
      nmi_q <= nmi_d;
      rrq_q <= rrq_d;
    end
  end

  assign nmi_o     = nmi_q;
  assign rst_req_o = rrq_q;

  always_comb begin
    case (bus_addr)
      OFS_CTRL:  bus_rdata = run ? UNLOCK_WORD : 32'h0;
      OFS_PRE:   bus_rdata = 32'(pre_pend);
      OFS_STS:   bus_rdata = {30'h0, sts_fault, 1'b0};
      OFS_CNT:   bus_rdata = 32'(cnt);
      OFS_REACT: bus_rdata = react_irq ? REACT_IRQ : REACT_RST;
      OFS_WIN:   bus_rdata = win_encode(wsh_pend);
      default:   bus_rdata = 32'h0;
    endcase
  end

  AST_REACT_EXCL: assert property (@(posedge clk) disable iff (!srst_n)
    !(nmi_q && rrq_q)); // R7

  AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!srst_n)
    (nmi_q || rrq_q) |-> sts_fault); // R6

  AST_ZERO_REACTS: assert property (@(posedge clk) disable iff (!srst_n)
    (run && cnt_zero) |=> (nmi_q || rrq_q)); // R5

endmodule

// File: tb/sim_winwdt_top.sv
`timescale 1ns/1ps
module sim_winwdt_top;

  localparam int PRE_W = 12;
  localparam int SHIFT = 2;
  localparam int P0    = 4;
  localparam int RLD   = P0 << SHIFT;

  localparam logic [7:0] A_CTRL = 8'h90, A_PRE = 8'h94, A_STS = 8'h98,
                         A_KEY = 8'h9C, A_CNT = 8'hA0, A_RX = 8'hA4, A_WIN = 8'hA8;
  localparam logic [31:0] K_EN = 32'hA98559DA, K_A = 32'hE51A, K_B = 32'hA35C;

  logic        clk, rst_n, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        nmi_o, rst_req_o;
  int          checks, errors;

  winwdt_top #(.PRE_W(PRE_W), .SHIFT(SHIFT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    checks = 0; errors = 0;

    // R4 / R3 / R7: sweep every window code against every service time
    for (int k = 1; k <= 5; k++) begin
      for (int n = 0; n <= RLD - 2; n++) begin
        bit irq_mode;
        bit exp_v;
        irq_mode = n[0];
        exp_v = ((RLD - n - 1) > (RLD >> k));
        do_reset();
        wr(A_PRE, 32'(P0));
        wr(A_WIN, 32'h50 << (4 * (k - 1)));
        wr(A_RX, irq_mode ? 32'hA : 32'h5);
        wr(A_CTRL, K_EN);
        idle(n);
        wr(A_KEY, K_A);
        wr(A_KEY, K_B);
        chk($sformatf("R4 irq k=%0d n=%0d", k, n), 32'(nmi_o), 32'(exp_v && irq_mode));
        chk($sformatf("R7 rst k=%0d n=%0d", k, n), 32'(rst_req_o), 32'(exp_v && !irq_mode));
        rd(A_STS, v);
        chk($sformatf("R6 sts k=%0d n=%0d", k, n), v, exp_v ? 32'h2 : 32'h0);
        rd(A_CNT, v);
        chk($sformatf("R3 reload k=%0d n=%0d", k, n), v, 32'(RLD));
      end
    end

    // R9 reset state
    do_reset();
    rd(A_CTRL, v);  chk("R9 ctrl", v, 32'h0);
    rd(A_STS, v);   chk("R9 sts", v, 32'h0);
    rd(A_CNT, v);   chk("R9 cnt", v, 32'h0);
    rd(A_PRE, v);   chk("R9 pre", v, 32'hFFF);
    rd(A_WIN, v);   chk("R9 win", v, 32'h50);
    rd(A_RX, v);    chk("R9 react", v, 32'h5);
    chk("R9 outs", {30'h0, nmi_o, rst_req_o}, 32'h0);

    // R1 wrong unlock word; R3 keys ignored while stopped
    wr(A_PRE, 32'(P0));
    wr(A_CTRL, K_EN ^ 32'h1);
    rd(A_CTRL, v);  chk("R1 bad unlock", v, 32'h0);
    wr(A_KEY, 32'h1234);
    wr(A_KEY, K_B);
    idle(2);
    rd(A_CNT, v);   chk("R1 idle cnt", v, 32'h0);
    rd(A_STS, v);   chk("R3 keys ignored sts", v, 32'h0);
    chk("R3 keys ignored outs", {30'h0, nmi_o, rst_req_o}, 32'h0);

    // R1 start and cannot stop; R2 countdown
    wr(A_CTRL, K_EN);
    rd(A_CTRL, v);  chk("R1 ctrl running", v, K_EN);
    rd(A_CNT, v);   chk("R2 reload value", v, 32'(RLD));
    idle(5);
    rd(A_CNT, v);   chk("R2 decrement", v, 32'(RLD - 5));
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v);  chk("R1 stop ignored", v, K_EN);
    rd(A_CNT, v);   chk("R1 still counting", v, 32'(RLD - 6));

    // R5 timeout
    idle(RLD - 6);
    rd(A_CNT, v);   chk("R5 at zero", v, 32'h0);
    chk("R5 no early pulse", 32'(rst_req_o), 32'h0);
    idle(1);
    chk("R5 timeout pulse", 32'(rst_req_o), 32'h1);
    chk("R5 timeout no irq", 32'(nmi_o), 32'h0);
    rd(A_STS, v);   chk("R6 set on timeout", v, 32'h2);
    rd(A_CNT, v);   chk("R5 reload after timeout", v, 32'(RLD));
    idle(1);
    chk("R7 single pulse", 32'(rst_req_o), 32'h0);

    // R6 write-one-to-clear
    wr(A_STS, 32'h1);
    rd(A_STS, v);   chk("R6 bit0 no clear", v, 32'h2);
    wr(A_STS, 32'h2);
    rd(A_STS, v);   chk("R6 w1c", v, 32'h0);

    // R5 wrong keys
    wr(A_KEY, 32'h1234);
    chk("R5 stray key", 32'(rst_req_o), 32'h1);
    wr(A_KEY, K_B);
    chk("R5 serve unarmed", 32'(rst_req_o), 32'h1);
    rd(A_CNT, v);   chk("R5 reload on bad key", v, 32'(RLD));

    // R8 held preload takes effect at next service
    wr(A_PRE, 32'h8);
    rd(A_PRE, v);   chk("R8 pre readback", v, 32'h8);
    rd(A_CNT, v);   chk("R8 held cnt", v, 32'(RLD - 1));
    idle(7);
    wr(A_KEY, K_A);
    wr(A_KEY, K_B);
    chk("R3 legal service", {30'h0, nmi_o, rst_req_o}, 32'h0);
    rd(A_CNT, v);   chk("R8 new period", v, 32'(8 << SHIFT));

    // R8 undefined window code ignored
    wr(A_WIN, 32'h55);
    rd(A_WIN, v);   chk("R8 bad code", v, 32'h50);
    wr(A_WIN, 32'h500);
    rd(A_WIN, v);   chk("R8 good code", v, 32'h500);

    // R7 reaction readback; R2 preload width
    wr(A_RX, 32'h7);
    rd(A_RX, v);    chk("R7 fallback", v, 32'h5);
    wr(A_RX, 32'hA);
    rd(A_RX, v);    chk("R7 irq sel", v, 32'hA);
    wr(A_PRE, 32'hFFFFF);
    rd(A_PRE, v);   chk("R2 pre mask", v, 32'hFFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule